// File: doc/BRIEF.md
# Selectable-Edge Trigger Interrupt Controller

This block turns an asynchronous external trigger line into a processor interrupt request. The raw line is brought into the clock domain through a chain of synchronizing flops. A polarity control then chooses whether a low-to-high or a high-to-low change counts as a trigger. An enable bit can block every interrupt. The synchronized line level is also offered as a status bit that does not depend on the interrupt path.

A qualified edge sets a sticky pending flag, and the flag drives an active-low request output. Firmware clears the flag with a one-cycle acknowledge strobe. Dropping the enable also clears it. During reset and after reset the request stays high until firmware sets the enable and a qualified edge arrives. Changing the polarity bit while the line is steady never counts as an edge, because the previous sample is kept as a raw level and both samples are adjusted by the same polarity.

Top module: `trig_irq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `irq_n` is 1 and `trig_level` shows the idle level `IDLE_LEVEL` (default 1).
- R2: `trig_level` equals `trig_in` delayed by `SYNC_STAGES` clock edges (default 2), whatever the values of `irq_en` and `pol_fall`.
- R3: With `pol_fall`=0 and `irq_en`=1, a 0-to-1 change on `trig_in` drives `irq_n` to 0 on the third clock edge after the change, and not before.
- R4: With `pol_fall`=1 and `irq_en`=1, a 1-to-0 change on `trig_in` drives `irq_n` to 0 on the third clock edge after the change.
- R5: A change in the direction opposite to the one `pol_fall` selects leaves `irq_n` at 1.
- R6: While `irq_en`=0, no change on `trig_in` drives `irq_n` low, and at any edge that samples `irq_en`=0 the request is cleared.
- R7: Once `irq_n` is low, it stays low until an edge samples `irq_ack`=1. It is 1 right after that edge.
- R8: If `irq_en` falls while a request is pending, `irq_n` returns to 1 and stays at 1 after `irq_en` is set again.
- R9: A change of `pol_fall` while `trig_in` is steady does not drive `irq_n` low.
- R10: If a qualified edge is detected in the same cycle that `irq_ack` is sampled, the new edge wins and `irq_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Raw external trigger line, asynchronous |
| pol_fall | input | 1 | 1 selects falling edges, 0 selects rising edges |
| irq_en | input | 1 | Interrupt enable; 0 blocks and clears the request |
| irq_ack | input | 1 | One-cycle strobe that clears the pending request |
| irq_n | output | 1 | Active-low interrupt request |
| trig_level | output | 1 | Synchronized trigger level, readable as status |

## Verification
A change on `trig_in` appears on `trig_level` after two clock edges, because it passes through two synchronizer flops. It reaches `irq_n` on the third edge, because the edge compare then loads the pending flop. An acknowledge strobe, or a low enable, takes effect on `irq_n` at the next edge. The bench drives every input at a falling clock edge and counts rising edges from that point. It checks `irq_n` one edge before the due edge, where it must still be inactive, and again at the due edge. The sweep covers every combination of polarity, enable and change direction, and the same timing applies in the acknowledge-collision case.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;
   // Edge selection decoded from the polarity control bit
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_sel_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RST_VALUE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   import trig_irq_pkg::*;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("trig_sync: STAGES must be at least %0d", MIN_SYNC_STAGES);
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VALUE;
            else        chain_q[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= RST_VALUE;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
   parameter logic RST_VALUE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   input  logic pol_fall,
   output logic edge_hit
);
   import trig_irq_pkg::*;

   edge_sel_e sel;
   logic      prev_raw_q;
   logic      cur_adj;
   logic      prev_adj;

   assign sel = edge_sel_e'(pol_fall);

   // The previous sample is stored as a raw level, so a polarity change
   // adjusts both samples alike and cannot make a false edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_raw_q <= RST_VALUE;
      else        prev_raw_q <= level;
   end

   always_comb begin
      cur_adj  = level      ^ (sel == EDGE_FALL);
      prev_adj = prev_raw_q ^ (sel == EDGE_FALL);
      edge_hit = cur_adj & ~prev_adj;
   end
endmodule

// File: rtl/trig_irq_latch.sv
module trig_irq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_hit,
   input  logic enable,
   input  logic ack,
   output logic pending
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pend_q <= 1'b0;
      else if (!enable)     pend_q <= 1'b0;
      else if (edge_hit)    pend_q <= 1'b1;   // new edge beats ack
      else if (ack)         pend_q <= 1'b0;
   end

   assign pending = pend_q;
endmodule

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        IDLE_LEVEL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   input  logic pol_fall,
   input  logic irq_en,
   input  logic irq_ack,
   output logic irq_n,
   output logic trig_level
);
   logic lvl_sync;
   logic edge_hit;
   logic pending;

   trig_sync #(
      .STAGES   (SYNC_STAGES),
      .RST_VALUE(IDLE_LEVEL)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(trig_in),
      .sync_out(lvl_sync)
   );

   trig_edge_det #(
      .RST_VALUE(IDLE_LEVEL)
   ) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level   (lvl_sync),
      .pol_fall(pol_fall),
      .edge_hit(edge_hit)
   );

   trig_irq_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .edge_hit(edge_hit),
      .enable  (irq_en),
      .ack     (irq_ack),
      .pending (pending)
   );

   assign irq_n      = ~pending;
   assign trig_level = lvl_sync;
endmodule

// File: rtl/trig_irq_ctrl_chk.sv
module trig_irq_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic pol_fall,
   input logic irq_en,
   input logic irq_ack,
   input logic irq_n,
   input logic trig_level
);
   // R1: inactive output while in reset
   always_comb begin
      if (!rst_n) a_r1_idle_in_reset : assert (irq_n === 1'b1 || irq_n === 1'bx);
   end

   // R6: a sampled low enable leaves the request inactive
   a_r6_disabled_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> irq_n);

   // R7: pending request holds without ack
   a_r7_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && irq_en && !irq_ack) |=> !irq_n);

   // R5: a new request follows an edge of the selected direction
   a_r5_polarity_match : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> $past(trig_level ^ pol_fall));

   // R9: polarity change on a steady line makes no request
   a_r9_pol_change_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(pol_fall) && $stable(trig_level) && irq_n) |=> irq_n);

   // R3: requests only appear while enabled
   a_r3_needs_enable : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> $past(irq_en));
endmodule

bind trig_irq_ctrl trig_irq_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pol_fall  (pol_fall),
   .irq_en    (irq_en),
   .irq_ack   (irq_ack),
   .irq_n     (irq_n),
   .trig_level(trig_level)
);

// File: tb/trig_irq_ctrl_tb.sv
module trig_irq_ctrl_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig_in = 1'b1;
   logic pol_fall = 1'b0;
   logic irq_en = 1'b0;
   logic irq_ack = 1'b0;
   logic irq_n;
   logic trig_level;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   trig_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .pol_fall(pol_fall),
      .irq_en(irq_en), .irq_ack(irq_ack), .irq_n(irq_n), .trig_level(trig_level)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // Bring the line to a level with interrupts disabled, then enable
   task automatic settle(input logic lvl, input logic pol);
      irq_en = 1'b0; pol_fall = pol; trig_in = lvl;
      tick(4);
      irq_en = 1'b1;
      tick(1);
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      tick(2);
      check("R1 irq_n in reset", irq_n, 1'b1);
      rst_n = 1'b1;
      tick(1);
      check("R1 irq_n after reset", irq_n, 1'b1);
      check("R1 idle level", trig_level, 1'b1);

      // Sweep: polarity x enable x direction (R3 R4 R5 R6)
      for (int p = 0; p < 2; p++) begin
         for (int e = 0; e < 2; e++) begin
            for (int d = 0; d < 2; d++) begin
               logic start_lvl;
               logic expect_irq;
               start_lvl  = (d == 1) ? 1'b0 : 1'b1;  // d=1: rising change
               expect_irq = (e == 1) && ((d == 1) ? (p == 0) : (p == 1));
               settle(start_lvl, p[0]);
               irq_en = e[0];
               tick(1);
               trig_in = ~start_lvl;
               tick(2);
               check("R2 level after two edges", trig_level, ~start_lvl);
               check("R3 not before third edge", irq_n, 1'b1);
               tick(1);
               if (e == 0)      check("R6 disabled", irq_n, 1'b1);
               else if (p == 0) check(d == 1 ? "R3 rising" : "R5 opposite", irq_n, ~expect_irq);
               else             check(d == 0 ? "R4 falling" : "R5 opposite", irq_n, ~expect_irq);
            end
         end
      end

      // R7: sticky until ack
      settle(1'b0, 1'b0);
      trig_in = 1'b1;
      tick(3);
      tick(5);
      check("R7 held", irq_n, 1'b0);
      irq_ack = 1'b1;
      tick(1);
      irq_ack = 1'b0;
      check("R7 cleared by ack", irq_n, 1'b1);

      // R8: enable drop clears pending
      settle(1'b0, 1'b0);
      trig_in = 1'b1;
      tick(3);
      check("R8 pending before drop", irq_n, 1'b0);
      irq_en = 1'b0;
      tick(1);
      check("R8 cleared", irq_n, 1'b1);
      irq_en = 1'b1;
      tick(2);
      check("R8 stays clear", irq_n, 1'b1);

      // R9: polarity toggle on steady line, both levels
      for (int l = 0; l < 2; l++) begin
         settle(l[0], 1'b0);
         pol_fall = 1'b1;
         tick(2);
         pol_fall = 1'b0;
         tick(2);
         check("R9 polarity change", irq_n, 1'b1);
      end

      // R10: ack in the cycle the edge is detected
      settle(1'b0, 1'b0);
      trig_in = 1'b1;
      tick(3);
      trig_in = 1'b0;
      tick(1);
      trig_in = 1'b1;
      tick(2);
      irq_ack = 1'b1;      // edge compare is active during this cycle
      tick(1);
      irq_ack = 1'b0;
      check("R10 edge beats ack", irq_n, 1'b0);

      // R2: level visible with interrupts disabled
      irq_en = 1'b0;
      trig_in = 1'b0;
      tick(1);
      check("R2 one edge not yet", trig_level, 1'b1);
      tick(1);
      check("R2 disabled level", trig_level, 1'b0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule